// File: doc/BRIEF.md
# Strided Sine Lookup Sequencer

This block turns a sample-rate tick into a stream of 8-bit offset-binary codes that trace one cycle of a sine wave. Each accepted tick presents the table entry at the current read pointer and then moves the pointer forward by a stride of 1, 2 or 4. The stride trades samples per cycle (64, 32 or 16) for output frequency: the tone frequency equals the tick rate divided by the samples per cycle, so a 3.84 kHz tick at stride 1 yields 60 Hz. The stride is doubled to 2 for twice the tone, or set to 4 for four times.

The sine cycle lives in a constant ROM that stores a single quarter wave and rebuilds the other three quarters by mirroring. A small control state machine gates the tick. In state IDLE all ticks are ignored. The transition IDLE to RUN takes place on the first clock edge that samples the enable high. In state RUN a tick is accepted while the enable is still high. The transition RUN to IDLE takes place on the first edge that samples the enable low. Disabling keeps the pointer and the last code, so a later enable resumes the wave where it stopped.

Top module: `sine_stride_seq`

## Requirements
- R1: Output codes are offset binary between 0 and 254 inclusive, with 127 as the zero-crossing level.
- R2: Table entry n equals round(127 + 127*sin(2*pi*n/64)); entry 0 is 127, entry 16 is 254, entry 32 is 127 and entry 48 is 0.
- R3: A tick that is accepted at a clock edge places the entry at the current pointer on sample_o after that edge and raises valid_o for exactly that one cycle; the pointer then moves forward by the stride.
- R4: When pointer plus stride is 64 or more, the pointer returns to 0, including when the pointer is not a multiple of the stride.
- R5: stride_sel_i encodes the stride as 2'b00 for 1, 2'b01 for 2, 2'b10 for 4, and 2'b11 for 1, which gives a waveform period of 64, 32, 16 and 64 accepted ticks.
- R6: A stride change applies to the next accepted tick and leaves the pointer untouched.
- R7: While reset is low, and after it is released, the pointer is 0, sample_o is 127 and valid_o is 0.
- R8: While the block is not accepting ticks, valid_o stays low, sample_o holds its last value and the pointer holds, so the next accepted tick continues the sequence.
- R9: A tick is accepted only in state RUN with en_i high at that edge; the state becomes RUN one edge after en_i is sampled high, and IDLE one edge after it is sampled low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sample-rate tick, one cycle per sample |
| en_i | input | 1 | Enable; gates ticks through the state machine |
| stride_sel_i | input | 2 | Stride select (see R5) |
| sample_o | output | 8 | Current offset-binary sine code |
| valid_o | output | 1 | One-cycle strobe when a new code is presented |

## Verification
A new code and its strobe are due one clock edge after the edge that accepts a tick, and a change of enable becomes visible in the state one edge later. A tick is accepted only on the edge after that. The bench keeps a behavioural model that applies these same edge rules to the inputs it drives on the falling edge, and compares sample_o and valid_o at every falling edge. Every result is therefore checked in the exact cycle it is due, and every cycle in which no result should appear is also checked. The sample list recorded at stride 1 is also inspected at entries 0, 16, 32 and 48.

// File: rtl/sine_seq_pkg.sv
package sine_seq_pkg;

    localparam int TBL_DEPTH = 64;
    localparam int PTR_W     = $clog2(TBL_DEPTH);
    localparam int QTR       = TBL_DEPTH / 4;
    localparam int CODE_W    = 8;
    localparam int MID_CODE  = 127;
    localparam int STEP_W    = 3;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;

    typedef enum logic [1:0] {
        STEP_ONE  = 2'b00,
        STEP_TWO  = 2'b01,
        STEP_FOUR = 2'b10,
        STEP_RSVD = 2'b11
    } step_sel_t;

    function automatic logic [STEP_W-1:0] stride_of(input logic [1:0] sel);
        logic [STEP_W-1:0] s;
        unique case (step_sel_t'(sel))
            STEP_ONE:  s = STEP_W'(1);
            STEP_TWO:  s = STEP_W'(2);
            STEP_FOUR: s = STEP_W'(4);
            STEP_RSVD: s = STEP_W'(1);
            default:   s = STEP_W'(1);
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sine_quarter_rom.sv
module sine_quarter_rom
    import sine_seq_pkg::*;
(
    input  logic [PTR_W-1:0]  idx_i,
    output logic [CODE_W-1:0] code_o
);

    localparam int QW = $clog2(QTR) + 1;

    logic [1:0]        quad;
    logic [QW-2:0]     phase;
    logic [QW-1:0]     qidx;
    logic [CODE_W-1:0] amp;

    assign quad  = idx_i[PTR_W-1:PTR_W-2];
    assign phase = idx_i[PTR_W-3:0];

    // Rising quarters read forward, falling quarters read mirrored.
    always_comb begin
        if (quad[0]) qidx = QW'(QTR) - {1'b0, phase};
        else         qidx = {1'b0, phase};
    end

    // Amplitude of the first quarter: round(127*sin(2*pi*k/64)), k = 0..16
    always_comb begin
        unique case (qidx)
            5'd0:    amp = 8'd0;
            5'd1:    amp = 8'd12;
            5'd2:    amp = 8'd25;
            5'd3:    amp = 8'd37;
            5'd4:    amp = 8'd49;
            5'd5:    amp = 8'd60;
            5'd6:    amp = 8'd71;
            5'd7:    amp = 8'd81;
            5'd8:    amp = 8'd90;
            5'd9:    amp = 8'd98;
            5'd10:   amp = 8'd106;
            5'd11:   amp = 8'd112;
            5'd12:   amp = 8'd117;
            5'd13:   amp = 8'd122;
            5'd14:   amp = 8'd125;
            5'd15:   amp = 8'd126;
            5'd16:   amp = 8'd127;
            default: amp = 8'd0;
        endcase
    end

    // Upper half of the cycle sits above midscale, lower half below.
    always_comb begin
        if (quad[1]) code_o = CODE_W'(MID_CODE) - amp;
        else         code_o = CODE_W'(MID_CODE) + amp;
    end

endmodule

// File: rtl/sine_ptr_step.sv
module sine_ptr_step
    import sine_seq_pkg::*;
(
    input  logic [PTR_W-1:0] ptr_i,
    input  logic [1:0]       sel_i,
    output logic [PTR_W-1:0] next_o
);

    logic [PTR_W:0]    sum;
    logic [STEP_W-1:0] step;

    assign step = stride_of(sel_i);
    assign sum  = {1'b0, ptr_i} + (PTR_W+1)'(step);

    // Any sum at or past the table end restarts the cycle at entry 0.
    always_comb begin
        if (sum >= (PTR_W+1)'(TBL_DEPTH)) next_o = '0;
        else                              next_o = sum[PTR_W-1:0];
    end

endmodule

// File: rtl/sine_seq_ctrl.sv
module sine_seq_ctrl
    import sine_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic tick_i,
    output logic accept_o
);

    seq_state_t state_q;
    seq_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: if (en_i)  state_d = SEQ_RUN;
            SEQ_RUN:  if (!en_i) state_d = SEQ_IDLE;
            default:  state_d = SEQ_IDLE;
        endcase
    end

    always_comb begin
        accept_o = 1'b0;
        unique case (state_q)
            SEQ_IDLE: accept_o = 1'b0;
            SEQ_RUN:  accept_o = en_i & tick_i;
            default:  accept_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/sine_stride_seq.sv
module sine_stride_seq
    import sine_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              en_i,
    input  logic [1:0]        stride_sel_i,
    output logic [CODE_W-1:0] sample_o,
    output logic              valid_o
);

    logic              accept;
    logic [PTR_W-1:0]  ptr_q;
    logic [PTR_W-1:0]  ptr_next;
    logic [CODE_W-1:0] rom_code;

    sine_seq_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en_i),
        .tick_i   (tick_i),
        .accept_o (accept)
    );

    sine_quarter_rom u_rom (
        .idx_i  (ptr_q),
        .code_o (rom_code)
    );

    sine_ptr_step u_step (
        .ptr_i  (ptr_q),
        .sel_i  (stride_sel_i),
        .next_o (ptr_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q    <= '0;
            sample_o <= CODE_W'(MID_CODE);
            valid_o  <= 1'b0;
        end else begin
            valid_o <= accept;
            if (accept) begin
                sample_o <= rom_code;
                ptr_q    <= ptr_next;
            end
        end
    end

endmodule

// File: rtl/sine_stride_seq_chk.sv
module sine_stride_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_i,
    input logic       en_i,
    input logic [7:0] sample_o,
    input logic       valid_o
);

    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (sample_o <= 8'd254)); // R1

    AST_VALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(tick_i && en_i)); // R3

    AST_RESET_MID: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sample_o == 8'd127 && !valid_o)); // R7

    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(sample_o)); // R8

    AST_DISABLE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !valid_o); // R9

endmodule

bind sine_stride_seq sine_stride_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_i),
    .en_i     (en_i),
    .sample_o (sample_o),
    .valid_o  (valid_o)
);

// File: tb/tb_sine_stride_seq.sv
module tb_sine_stride_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       en_i = 1'b0;
    logic [1:0] stride_sel_i = 2'b00;
    logic [7:0] sample_o;
    logic       valid_o;

    int    n_checks = 0;
    int    n_errors = 0;
    int    cycles = 0;
    string cur_req = "R7";

    int tbl[64];
    int m_ptr = 0;
    int m_sample = 127;
    bit m_valid = 1'b0;
    bit m_run = 1'b0;
    bit rec_on = 1'b0;
    int rec_q[$];
    int seen_max = 0;
    int seen_min = 255;

    always #4 clk = ~clk;

    sine_stride_seq dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_i),
        .en_i         (en_i),
        .stride_sel_i (stride_sel_i),
        .sample_o     (sample_o),
        .valid_o      (valid_o)
    );

    initial begin
        for (int n = 0; n < 64; n++)
            tbl[n] = $rtoi(127.0 + 127.0 * $sin(2.0 * 3.14159265358979 * n / 64.0) + 0.5);
    end

    function automatic int step_of(input logic [1:0] s);
        if (s == 2'b01) return 2;
        if (s == 2'b10) return 4;
        return 1;
    endfunction

    // Behavioural reference model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ptr = 0; m_sample = 127; m_valid = 1'b0; m_run = 1'b0;
        end else begin
            if (m_run && en_i && tick_i) begin
                m_sample = tbl[m_ptr];
                m_valid = 1'b1;
                if (rec_on) rec_q.push_back(m_sample);
                if (m_ptr + step_of(stride_sel_i) >= 64) m_ptr = 0;
                else m_ptr = m_ptr + step_of(stride_sel_i);
            end else begin
                m_valid = 1'b0;
            end
            m_run = en_i;
        end
    end

    task automatic check(input string req, input int act, input int exp, input string what);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        check(cur_req, int'(sample_o), m_sample, "sample_o");
        check(cur_req, int'(valid_o), int'(m_valid), "valid_o");
        if (valid_o) begin
            if (sample_o > seen_max) seen_max = sample_o;
            if (sample_o < seen_min) seen_min = sample_o;
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        wait (cycles > 100000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            tick_i = 1'b0;
        end
    endtask

    task automatic ticks(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            tick_i = 1'b1;
            @(negedge clk); #1;
            tick_i = 1'b0;
            if (gap > 0) idle(gap);
        end
    endtask

    initial begin
        // R7: reset state
        cur_req = "R7";
        idle(3);
        rst_n = 1'b1;
        idle(2);
        check("R7", int'(sample_o), 127, "sample after reset");

        // R3 / R2: stride 1, one full cycle plus wrap (R4)
        cur_req = "R3";
        en_i = 1'b1;
        rec_on = 1'b1;
        idle(1);
        ticks(70, 2);
        rec_on = 1'b0;
        check("R2", rec_q[0], 127, "entry 0");
        check("R2", rec_q[16], 254, "entry 16");
        check("R2", rec_q[32], 127, "entry 32");
        check("R2", rec_q[48], 0, "entry 48");
        check("R4", rec_q[64], 127, "wrap back to entry 0");

        // R5: stride 2, back-to-back ticks
        cur_req = "R5";
        stride_sel_i = 2'b01;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); #1; tick_i = 1'b1;
        end
        idle(2);
        // R5: stride 4
        stride_sel_i = 2'b10;
        ticks(20, 1);
        // R5: reserved code acts as stride 1
        stride_sel_i = 2'b11;
        ticks(10, 0);

        // R6 / R4: odd pointer then stride 4 past the end
        cur_req = "R6";
        stride_sel_i = 2'b00;
        ticks(1, 0);
        stride_sel_i = 2'b10;
        cur_req = "R4";
        ticks(20, 0);

        // R8: disabled, ticks ignored, output and pointer hold
        cur_req = "R8";
        en_i = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); #1; tick_i = 1'b1;
        end
        idle(1);

        // R9: tick on the edge that first sees enable high is ignored
        cur_req = "R9";
        @(negedge clk); #1; en_i = 1'b1; tick_i = 1'b1;
        @(negedge clk); #1; tick_i = 1'b1;
        @(negedge clk); #1; tick_i = 1'b0;
        // R9: tick on the edge with enable low is blocked
        @(negedge clk); #1; en_i = 1'b0; tick_i = 1'b1;
        @(negedge clk); #1; en_i = 1'b1; tick_i = 1'b0;
        idle(1);
        ticks(12, 1);
        idle(3);

        check("R1", seen_max, 254, "largest code seen");
        check("R1", seen_min, 0, "smallest code seen");
        finish_run();
    end

endmodule